// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block sits in the master-clock domain of an audio output path. It watches an asynchronous frame clock, which toggles once per stereo sample. It measures how many master-clock cycles make up one frame and snaps the measurement onto a sparse set of legal master-to-frame ratios. From the locked ratio it reports a sample-rate speed class. It holds the audio path in a powered-down, muted condition until a frame clock is present and a stable ratio has been confirmed.

Several ratios are legal in two speed classes. The block cannot measure absolute frequency, so a static hint input settles those cases: the hint is high when the master clock runs in its fast range. After a ratio is accepted, the block keeps the output muted for a configurable number of further frames so that the downstream data path can settle. A ratio that changes while the block is locked drops the lock at once, and the block re-detects. If the frame clock stops, the block returns to power-down. The block has no data stream, so every pin is a plain level.

Top module: `clk_ratio_detect`

## Requirements
- R1: After reset, `powered_down`=1, `mute`=1, `ratio_valid`=0, `ratio_err`=0, and `ratio_nom` and `speed_mode` are 0.
- R2: `frame_clk` passes through a two-flop synchronizer. The block leaves power-down on the first synchronized rising edge. A frame count is the number of `clk` cycles between two consecutive synchronized rising edges.
- R3: A ratio is accepted only when two consecutive frame counts differ by at most TOL (default 2) and the second count lies within ±TOL of one of 64, 96, 128, 192, 256, 384, 512, 768, 1024 or 1152. On acceptance, `ratio_valid` goes to 1 and `ratio_nom` holds that legal value.
- R4: `speed_mode` uses the codes 0 = single, 1 = double and 2 = quad. Ratios 64 and 96 give quad, and ratios of 512 and above give single. Ratios 128 and 192 give quad if `fast_hint`=1 and double otherwise. Ratios 256 and 384 give double if `fast_hint`=1 and single otherwise. The hint is sampled at acceptance.
- R5: `ratio_err` goes to 1 when a pair of consecutive counts is rejected, either because they differ by more than TOL or because the count is not near a legal ratio. It stays set until a later acceptance or a return to power-down. While `ratio_err` is 1, `ratio_valid` stays 0.
- R6: After acceptance, `mute` stays 1 until SETTLE_FRAMES further frame counts have matched the locked ratio within ±TOL. `mute` then goes to 0.
- R7: While the block is locked, a frame count outside ±TOL of `ratio_nom` clears `ratio_valid` and sets `mute`. That count becomes the first of a new pair. Counts within ±TOL keep the lock.
- R8: If the synchronized frame clock does not toggle for ABSENT_CYCLES (default 2048) clock cycles, the block returns to the power-down state of R1, but keeps the last `ratio_nom` and `speed_mode`.
- R9: `mute` is 1 whenever `ratio_valid` is 0. `ratio_nom` and `speed_mode` do not change while `ratio_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Asynchronous frame (sample) clock |
| fast_hint | input | 1 | High when the master clock is in its fast range |
| powered_down | output | 1 | Block is in power-down |
| ratio_valid | output | 1 | A ratio is locked |
| ratio_err | output | 1 | Last count pair was rejected |
| mute | output | 1 | Downstream must force zero data |
| speed_mode | output | 2 | 0 single, 1 double, 2 quad |
| ratio_nom | output | 11 | Locked nominal master-to-frame ratio |

## Verification
On every cycle, the assertions check the relations between the status outputs. These are: power-down implies muted and unlocked, an unlocked or erroring block is muted, a locked ratio is always a legal value, and the speed code agrees with the unambiguous ratios and stays fixed while locked. Other behaviours depend on long frame sequences, and only the bench scenarios can show them. These are the exact frame on which the lock and the mute release happen, the ±TOL acceptance boundary, error raising and clearing, re-detection after a ratio change, and the timeout of an absent frame clock. The bench sweeps every legal ratio with both hint values in a short-settle configuration.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int NUM_RATIOS = 10;
  localparam int RATIO_W    = 11;
  localparam int IDX_W      = $clog2(NUM_RATIOS);

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  typedef enum logic [1:0] {
    ST_PWRDN  = 2'd0,
    ST_ACQ    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } det_state_e;

  // Legal ratios in ascending order: 64/96 pairs doubling up to 768, then 1024, 1152.
  function automatic logic [RATIO_W-1:0] legal_ratio(input int idx);
    if (idx < 8)
      return RATIO_W'(((idx % 2) == 0 ? 64 : 96) << (idx / 2));
    else if (idx == 8)
      return RATIO_W'(1024);
    else
      return RATIO_W'(1152);
  endfunction

  // Speed class for a ratio index; overlapping ratios use the fast hint.
  function automatic speed_e speed_for(input int idx, input logic fast);
    if (idx <= 1)      return SPD_QUAD;
    else if (idx <= 3) return fast ? SPD_QUAD : SPD_DOUBLE;
    else if (idx <= 5) return fast ? SPD_DOUBLE : SPD_SINGLE;
    else               return SPD_SINGLE;
  endfunction
endpackage

// File: rtl/crd_sync.sv
module crd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic toggle
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise   = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign toggle = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/crd_period.sv
module crd_period #(
  parameter int CNT_W         = 12,
  parameter int ABSENT_CYCLES = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             toggle,
  output logic [CNT_W-1:0] len,
  output logic             absent
);
  localparam int IDLE_W = $clog2(ABSENT_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_SAT  = '1;
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(ABSENT_CYCLES);

  logic [CNT_W-1:0]  run_q;
  logic [IDLE_W-1:0] idle_q;

  // Cycles since the last rising edge; read out as the frame count on a rise.
  always_ff @(posedge clk) begin
    if (!rst_n)                run_q <= '0;
    else if (rise)             run_q <= CNT_W'(1);
    else if (run_q != CNT_SAT) run_q <= run_q + CNT_W'(1);
  end

  // Cycles since the last toggle of either polarity.
  always_ff @(posedge clk) begin
    if (!rst_n || toggle)        idle_q <= '0;
    else if (idle_q != IDLE_LIM) idle_q <= idle_q + IDLE_W'(1);
  end

  assign len    = run_q;
  assign absent = (idle_q == IDLE_LIM) && !toggle;
endmodule

// File: rtl/crd_classify.sv
module crd_classify
  import crd_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] count,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [NUM_RATIOS-1:0] match;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_cmp
    localparam int NOM = int'(legal_ratio(g));
    assign match[g] = (int'(count) >= NOM - TOL) && (int'(count) <= NOM + TOL);
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import crd_pkg::*;
#(
  parameter int TOL           = 2,
  parameter int SETTLE_FRAMES = 2000,
  parameter int ABSENT_CYCLES = 2048,
  parameter int SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_clk,
  input  logic               fast_hint,
  output logic               powered_down,
  output logic               ratio_valid,
  output logic               ratio_err,
  output logic               mute,
  output logic [1:0]         speed_mode,
  output logic [RATIO_W-1:0] ratio_nom
);
  localparam int CNT_W = RATIO_W + 1;
  localparam int SET_W = $clog2(SETTLE_FRAMES + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_FRAMES - 1);

  logic             rise, toggle, absent, hit;
  logic [CNT_W-1:0] len;
  logic [IDX_W-1:0] idx;

  crd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(frame_clk), .rise(rise), .toggle(toggle)
  );

  crd_period #(.CNT_W(CNT_W), .ABSENT_CYCLES(ABSENT_CYCLES)) u_period (
    .clk(clk), .rst_n(rst_n), .rise(rise), .toggle(toggle), .len(len), .absent(absent)
  );

  crd_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
    .count(len), .hit(hit), .idx(idx)
  );

  det_state_e       state_q;
  logic [CNT_W-1:0] prev_q;
  logic             have_prev_q;
  logic [SET_W-1:0] settle_q;
  logic             valid_q, err_q, mute_q;
  speed_e           speed_q;
  logic [RATIO_W-1:0] ratio_q;

  logic pair_ok, in_lock;
  int   diff;

  always_comb begin
    diff    = int'(len) - int'(prev_q);
    pair_ok = (diff <= TOL) && (diff >= -TOL);
    in_lock = (int'(len) >= int'(ratio_q) - TOL) && (int'(len) <= int'(ratio_q) + TOL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_PWRDN;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      settle_q    <= '0;
      valid_q     <= 1'b0;
      err_q       <= 1'b0;
      mute_q      <= 1'b1;
      speed_q     <= SPD_SINGLE;
      ratio_q     <= '0;
    end else if (absent) begin
      state_q     <= ST_PWRDN;
      have_prev_q <= 1'b0;
      valid_q     <= 1'b0;
      err_q       <= 1'b0;
      mute_q      <= 1'b1;
    end else begin
      unique case (state_q)
        ST_PWRDN: begin
          if (rise) begin
            state_q     <= ST_ACQ;
            have_prev_q <= 1'b0;
          end
        end
        ST_ACQ: begin
          if (rise) begin
            prev_q      <= len;
            have_prev_q <= 1'b1;
            if (have_prev_q) begin
              if (pair_ok && hit) begin
                ratio_q  <= legal_ratio(int'(idx));
                speed_q  <= speed_for(int'(idx), fast_hint);
                valid_q  <= 1'b1;
                err_q    <= 1'b0;
                settle_q <= '0;
                state_q  <= ST_SETTLE;
              end else begin
                err_q <= 1'b1;
              end
            end
          end
        end
        ST_SETTLE: begin
          if (rise) begin
            if (!in_lock) begin
              valid_q     <= 1'b0;
              prev_q      <= len;
              have_prev_q <= 1'b1;
              state_q     <= ST_ACQ;
            end else if (settle_q == SET_LAST) begin
              mute_q  <= 1'b0;
              state_q <= ST_RUN;
            end else begin
              settle_q <= settle_q + SET_W'(1);
            end
          end
        end
        ST_RUN: begin
          if (rise && !in_lock) begin
            valid_q     <= 1'b0;
            mute_q      <= 1'b1;
            prev_q      <= len;
            have_prev_q <= 1'b1;
            state_q     <= ST_ACQ;
          end
        end
      endcase
    end
  end

  assign powered_down = (state_q == ST_PWRDN);
  assign ratio_valid  = valid_q;
  assign ratio_err    = err_q;
  assign mute         = mute_q;
  assign speed_mode   = speed_q;
  assign ratio_nom    = ratio_q;
endmodule

// File: rtl/crd_checker.sv
module crd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        powered_down,
  input logic        ratio_valid,
  input logic        ratio_err,
  input logic        mute,
  input logic [1:0]  speed_mode,
  input logic [10:0] ratio_nom
);
  logic legal;
  assign legal = (ratio_nom == 11'd64)  || (ratio_nom == 11'd96)  ||
                 (ratio_nom == 11'd128) || (ratio_nom == 11'd192) ||
                 (ratio_nom == 11'd256) || (ratio_nom == 11'd384) ||
                 (ratio_nom == 11'd512) || (ratio_nom == 11'd768) ||
                 (ratio_nom == 11'd1024) || (ratio_nom == 11'd1152);

  a_r1_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |-> (!ratio_valid && mute && !ratio_err));

  a_r9_mute_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_valid |-> mute);

  a_r3_legal_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid |-> legal);

  a_r5_err_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |-> !ratio_valid);

  a_r9_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && $past(ratio_valid)) |-> ($stable(ratio_nom) && $stable(speed_mode)));

  a_r4_speed_code: assert property (@(posedge clk) disable iff (!rst_n)
    speed_mode != 2'd3);

  a_r4_low_ratio_quad: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && ratio_nom <= 11'd96) |-> speed_mode == 2'd2);

  a_r4_high_ratio_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid && ratio_nom >= 11'd512) |-> speed_mode == 2'd0);

  a_r6_release_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> ratio_valid);
endmodule

bind clk_ratio_detect crd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .powered_down(powered_down), .ratio_valid(ratio_valid),
  .ratio_err(ratio_err), .mute(mute), .speed_mode(speed_mode), .ratio_nom(ratio_nom)
);

// File: tb/sim_clk_ratio_detect.sv
module sim_clk_ratio_detect;
  localparam int SETTLE = 4;
  localparam int ABSENT = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b0;
  logic fast_hint = 1'b0;
  logic powered_down, ratio_valid, ratio_err, mute;
  logic [1:0]  speed_mode;
  logic [10:0] ratio_nom;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  clk_ratio_detect #(.TOL(2), .SETTLE_FRAMES(SETTLE), .ABSENT_CYCLES(ABSENT)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .fast_hint(fast_hint),
    .powered_down(powered_down), .ratio_valid(ratio_valid), .ratio_err(ratio_err),
    .mute(mute), .speed_mode(speed_mode), .ratio_nom(ratio_nom)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  function automatic int exp_ratio(input int i);
    case (i)
      0: return 64;   1: return 96;   2: return 128;  3: return 192;
      4: return 256;  5: return 384;  6: return 512;  7: return 768;
      8: return 1024; default: return 1152;
    endcase
  endfunction

  function automatic int exp_speed(input int r, input bit fast);
    if (r >= 512) return 0;
    if (r <= 96)  return 2;
    if (r <= 192) return fast ? 2 : 1;
    return fast ? 1 : 0;
  endfunction

  task automatic do_reset();
    rst_n     = 1'b0;
    frame_clk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_frame(input int len);
    frame_clk = 1'b1;
    repeat (len / 2) @(negedge clk);
    frame_clk = 1'b0;
    repeat (len - len / 2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk_eq("R1 powered_down", int'(powered_down), 1);
    chk_eq("R1 mute", int'(mute), 1);
    chk_eq("R1 ratio_valid", int'(ratio_valid), 0);
    chk_eq("R1 ratio_err", int'(ratio_err), 0);
    chk_eq("R1 ratio_nom", int'(ratio_nom), 0);
    chk_eq("R1 speed_mode", int'(speed_mode), 0);

    // Sweep every legal ratio under both hint values
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < 10; i++) begin
        int r;
        r = exp_ratio(i);
        fast_hint = h[0];
        do_reset();
        for (int f = 1; f <= 7; f++) begin
          do_frame(r);
          if (f == 1) chk_eq("R2 leaves power-down", int'(powered_down), 0);
          if (f == 2) chk_eq("R3 no lock on single count", int'(ratio_valid), 0);
          if (f == 3) begin
            chk_eq("R3 locked", int'(ratio_valid), 1);
            chk_eq("R3 ratio_nom", int'(ratio_nom), r);
            chk_eq("R4 speed_mode", int'(speed_mode), exp_speed(r, h[0]));
            chk_eq("R6 muted at lock", int'(mute), 1);
          end
          if (f == 6) chk_eq("R6 muted before settle ends", int'(mute), 1);
          if (f == 7) chk_eq("R6 released after settle", int'(mute), 0);
        end
      end
    end

    // R3 tolerance edge: counts 256 then 258 accepted as 256
    fast_hint = 1'b0;
    do_reset();
    do_frame(256); do_frame(258); do_frame(256);
    chk_eq("R3 accept at +TOL", int'(ratio_valid), 1);
    chk_eq("R3 snapped ratio", int'(ratio_nom), 256);

    // R5 mismatched pair, then illegal stable count, then recovery
    do_reset();
    do_frame(256); do_frame(259); do_frame(259);
    chk_eq("R5 err on pair mismatch", int'(ratio_err), 1);
    chk_eq("R5 not valid on mismatch", int'(ratio_valid), 0);
    do_frame(259); do_frame(256);
    chk_eq("R5 err on illegal count", int'(ratio_err), 1);
    chk_eq("R5 muted while err", int'(mute), 1);
    do_frame(256); do_frame(256);
    chk_eq("R5 err cleared on accept", int'(ratio_err), 0);
    chk_eq("R5 valid after recovery", int'(ratio_valid), 1);

    // R7 jitter within tolerance keeps lock; real change re-detects
    do_reset();
    for (int f = 0; f < 7; f++) do_frame(384);
    chk_eq("R6 released at 384", int'(mute), 0);
    do_frame(386); do_frame(382); do_frame(768);
    chk_eq("R7 lock kept under jitter", int'(ratio_valid), 1);
    chk_eq("R7 unmuted under jitter", int'(mute), 0);
    do_frame(768);
    chk_eq("R7 lock dropped on change", int'(ratio_valid), 0);
    chk_eq("R7 muted on change", int'(mute), 1);
    do_frame(768);
    chk_eq("R7 relocked", int'(ratio_valid), 1);
    chk_eq("R7 new ratio", int'(ratio_nom), 768);
    chk_eq("R7 new speed", int'(speed_mode), 0);
    chk_eq("R7 muted after relock", int'(mute), 1);
    do_frame(768); do_frame(768); do_frame(768);
    chk_eq("R7 muted during settle", int'(mute), 1);
    do_frame(768);
    chk_eq("R7 released after settle", int'(mute), 0);

    // R8 absence timeout
    do_reset();
    for (int f = 0; f < 7; f++) do_frame(256);
    idle(1800);
    chk_eq("R8 no early power-down", int'(powered_down), 0);
    chk_eq("R8 still locked", int'(ratio_valid), 1);
    idle(300);
    chk_eq("R8 power-down", int'(powered_down), 1);
    chk_eq("R8 unlocked", int'(ratio_valid), 0);
    chk_eq("R8 muted", int'(mute), 1);
    chk_eq("R8 err clear", int'(ratio_err), 0);
    do_frame(256);
    chk_eq("R2 wakes again", int'(powered_down), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule